// File: doc/BRIEF.md
# Dual-Issue Pair Steering

This block sits between instruction fetch and two execution pipelines, one for integer work and one for floating-point work. Each cycle the fetch side offers a 64-bit word that holds two 32-bit instructions. The block decides whether to send the first, both or neither of them to the pipelines. It routes each instruction to the pipeline that matches its class, and it tells fetch when the word has been fully consumed. Issue stays strictly in program order. The lower half of the word is always the older instruction.

The expected pairing template puts an integer-class instruction in the lower half and a floating-point instruction in the upper half. A pair that fits the template and has no hazard issues in a single cycle. A pair that does not fit is split. The lower instruction goes first and the upper one follows alone in the next cycle. A load's result becomes usable two cycles after the load issues. That blocks a consumer in the same pair and any consumer in the pair that follows. The fetch source must hold its word until `fetch_ready` is seen high.

Instruction format, with IW=32 and RW=5: class in bits [31:30], destination register in [29:25], first source in [24:20], second source in [19:15]. Class codes: 00 integer ALU, 01 load (integer pipeline), 10 store/branch (integer pipeline, no destination), 11 floating-point op. Registers share one namespace. Register 0 never carries a dependence.

Top module: `dual_issue_steer`

## Requirements
- R1: While `rst` is high, all of `int_issue`, `fp_issue`, `fetch_ready` and `stall` are 0. After `rst` is released, no retry is pending, no load is tracked, and the next word starts at its lower instruction.
- R2: A word whose lower instruction has a class other than 11 and whose upper instruction has class 11, with no hazard, issues both in one cycle. `int_instr` carries the lower instruction, `fp_instr` carries the upper one, and `fetch_ready` is 1.
- R3: The upper instruction never issues before the lower one. When the lower instruction is blocked, neither issues, `fetch_ready` is 0 and the word is held.
- R4: If the lower instruction is a load whose nonzero destination equals a source of the upper instruction, only the lower one issues. The upper one is blocked in the next cycle and issues in the cycle after that.
- R5: An instruction in either slot whose source equals the nonzero destination of a load issued in the previous cycle does not issue in the current cycle.
- R6: Destination or source register 0 never causes a load-use block.
- R7: When only the lower instruction issues, the next cycle considers the upper instruction alone. `int_issue` for a new word does not occur, and `fetch_ready` rises in the cycle the upper instruction issues.
- R8: A word that does not fit the template issues its lower instruction alone and its upper instruction alone in a later cycle. Each goes to the pipeline of its own class: class 11 on `fp_issue`/`fp_instr`, any other class on `int_issue`/`int_instr`.
- R9: While `flush` is high, nothing issues, `fetch_ready` is 1, `stall` is 0, and a pending upper-slot retry is discarded.
- R10: `stall` is 1 exactly when a word is offered, `flush` and `rst` are low, and the word is not consumed that cycle.
- R11: A load block lasts exactly one cycle. A blocked instruction issues in the following cycle if nothing else blocks it. A load issued from a retried upper slot also blocks the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard the offered word and any pending retry |
| fetch_valid | input | 1 | Fetch word is offered |
| fetch_word | input | 64 | Two instructions, older in [31:0] |
| fetch_ready | output | 1 | Offered word consumed this cycle |
| int_issue | output | 1 | Issue to integer pipeline |
| int_instr | output | 32 | Instruction sent to integer pipeline |
| fp_issue | output | 1 | Issue to floating-point pipeline |
| fp_instr | output | 32 | Instruction sent to floating-point pipeline |
| stall | output | 1 | Offered word held this cycle |

## Verification
Some rules can be checked on every cycle: the quiet outputs under reset, the flush behaviour, the tie between stall and fetch_ready, the rule that a dual issue always consumes the word, the rule that a partial issue is never followed by a dual issue, and the rule that nothing issued in a cycle reads the destination of a load issued the cycle before. Other behaviour only the bench scenarios can show. That includes the exact cycle in which a blocked instruction finally issues, the routing of split words by class, and the fact that a retry starts from the upper instruction, not the lower one. The bench sweeps every class combination of the two slots, with and without a partner dependence, and then runs directed sequences for back-to-back pairs, register 0, flush and reset during a retry.

// File: rtl/dual_issue_steer.sv
module dual_issue_steer #(
  parameter int IW = 32,
  parameter int RW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            fetch_valid,
  input  logic [2*IW-1:0] fetch_word,
  output logic            fetch_ready,
  output logic            int_issue,
  output logic [IW-1:0]   int_instr,
  output logic            fp_issue,
  output logic [IW-1:0]   fp_instr,
  output logic            stall
);
  localparam int DH = IW - 3;
  localparam int AH = DH - RW;
  localparam int BH = AH - RW;
  localparam logic [1:0] C_LD = 2'b01;
  localparam logic [1:0] C_FP = 2'b11;

  function automatic logic [1:0] cls(input logic [IW-1:0] i);
    return i[IW-1:IW-2];
  endfunction

  function automatic logic [RW-1:0] dst(input logic [IW-1:0] i);
    return i[DH -: RW];
  endfunction

  function automatic logic reads(input logic [IW-1:0] i, input logic [RW-1:0] r);
    return (r != '0) && (i[AH -: RW] == r || i[BH -: RW] == r);
  endfunction

  logic          pend;
  logic          ld_v;
  logic [RW-1:0] ld_d;

  logic [IW-1:0] lo, hi, head;
  logic          live, head_go, head_fp, fits, part_hz, pair_go, consumed;

  assign lo   = fetch_word[IW-1:0];
  assign hi   = fetch_word[2*IW-1:IW];
  assign head = pend ? hi : lo;
  assign live = fetch_valid && !flush && !rst;

  assign head_go = live && !(ld_v && reads(head, ld_d));
  assign head_fp = cls(head) == C_FP;
  assign fits    = cls(lo) != C_FP && cls(hi) == C_FP;
  assign part_hz = cls(lo) == C_LD && reads(hi, dst(lo));
  assign pair_go = head_go && !pend && fits && !part_hz && !(ld_v && reads(hi, ld_d));

  assign consumed    = head_go && (pend || pair_go);
  assign int_issue   = head_go && !head_fp;
  assign fp_issue    = (head_go && head_fp) || pair_go;
  assign int_instr   = head;
  assign fp_instr    = pair_go ? hi : head;
  assign fetch_ready = !rst && (flush || consumed);
  assign stall       = live && !consumed;

  always_ff @(posedge clk) begin
    if (rst || flush)
      pend <= 1'b0;
    else if (live)
      pend <= pend ? !head_go : (head_go && !pair_go);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_v <= 1'b0;
      ld_d <= '0;
    end else begin
      ld_v <= int_issue && cls(head) == C_LD && dst(head) != '0;
      ld_d <= dst(head);
    end
  end
endmodule

// File: rtl/dual_issue_steer_chk.sv
module dual_issue_steer_chk #(
  parameter int IW = 32,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          fetch_valid,
  input logic          fetch_ready,
  input logic          int_issue,
  input logic [IW-1:0] int_instr,
  input logic          fp_issue,
  input logic [IW-1:0] fp_instr,
  input logic          stall
);
  localparam int DH = IW - 3;
  localparam int AH = DH - RW;
  localparam int BH = AH - RW;

  function automatic logic uses(input logic [IW-1:0] i, input logic [RW-1:0] r);
    return (r != '0) && (i[AH -: RW] == r || i[BH -: RW] == r);
  endfunction

  logic          was_ld;
  logic [RW-1:0] ld_dst;
  assign was_ld = int_issue && int_instr[IW-1:IW-2] == 2'b01;
  assign ld_dst = int_instr[DH -: RW];

  always_comb begin
    if (rst)
      a_r1_reset_quiet: assert (!int_issue && !fp_issue && !fetch_ready && !stall);
  end

  a_r9_flush_drops: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!int_issue && !fp_issue && fetch_ready && !stall));

  a_r10_stall_holds: assert property (@(posedge clk) disable iff (rst)
    stall |-> (fetch_valid && !fetch_ready && !flush));

  a_r2_pair_consumes: assert property (@(posedge clk) disable iff (rst)
    (int_issue && fp_issue) |-> fetch_ready);

  a_r7_retry_alone: assert property (@(posedge clk) disable iff (rst)
    (stall && (int_issue || fp_issue)) |=> !(int_issue && fp_issue));

  a_r5_load_use: assert property (@(posedge clk) disable iff (rst)
    $past(was_ld) |-> (!(int_issue && uses(int_instr, $past(ld_dst))) &&
                       !(fp_issue && uses(fp_instr, $past(ld_dst)))));
endmodule

bind dual_issue_steer dual_issue_steer_chk #(.IW(IW), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .fetch_valid(fetch_valid),
  .fetch_ready(fetch_ready), .int_issue(int_issue), .int_instr(int_instr),
  .fp_issue(fp_issue), .fp_instr(fp_instr), .stall(stall)
);

// File: tb/test_dual_issue_steer.sv
module test_dual_issue_steer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [63:0] fetch_word = '0;
  logic        fetch_ready, int_issue, fp_issue, stall;
  logic [31:0] int_instr, fp_instr;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dual_issue_steer i_dual_issue_steer (
    .clk(clk), .rst(rst), .flush(flush), .fetch_valid(fetch_valid),
    .fetch_word(fetch_word), .fetch_ready(fetch_ready), .int_issue(int_issue),
    .int_instr(int_instr), .fp_issue(fp_issue), .fp_instr(fp_instr), .stall(stall)
  );

  function automatic logic [31:0] mk(input logic [1:0] c, input logic [4:0] d,
                                     input logic [4:0] a, input logic [4:0] b,
                                     input logic [14:0] tag);
    return {c, d, a, b, tag};
  endfunction

  task automatic drive(input logic v, input logic [63:0] w, input logic fl);
    @(negedge clk);
    fetch_valid = v;
    fetch_word  = w;
    flush       = fl;
    #1;
  endtask

  task automatic chk(input string req, input logic ii, input logic fi,
                     input logic rd, input logic st);
    checks++;
    if ({int_issue, fp_issue, fetch_ready, stall} !== {ii, fi, rd, st}) begin
      fails++;
      $display("FAIL %s: int/fp/ready/stall actual %b%b%b%b expected %b%b%b%b", req,
               int_issue, fp_issue, fetch_ready, stall, ii, fi, rd, st);
    end
  endtask

  task automatic chki(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: instr actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] l, r, l2, r2;
    logic [1:0]  c_alu = 2'b00, c_ld = 2'b01, c_fp = 2'b11;

    // R1: quiet during reset
    #1;
    chk("R1", 0, 0, 0, 0);
    drive(1, {mk(c_fp,6,3,4,1), mk(c_alu,5,1,2,2)}, 0);
    chk("R1", 0, 0, 0, 0);
    @(negedge clk);
    rst = 1'b0;
    fetch_valid = 1'b0;
    #1;
    chk("R10", 0, 0, 0, 0);

    // Sweep: every class pair, with and without partner dependence
    for (int lc = 0; lc < 4; lc++)
      for (int rc = 0; rc < 4; rc++)
        for (int hz = 0; hz < 2; hz++) begin
          logic fit, blk;
          l = mk(lc[1:0], 5, 1, 2, 15'(lc*8 + rc*2 + hz));
          r = mk(rc[1:0], 6, hz ? 5'd5 : 5'd3, 4, 15'(100 + lc*8 + rc*2 + hz));
          blk = (lc == 1) && (hz == 1);
          fit = (lc != 3) && (rc == 3) && !blk;
          drive(0, '0, 0);
          chk("R10", 0, 0, 0, 0);
          drive(1, {r, l}, 0);
          if (fit) begin
            chk("R2", 1, 1, 1, 0);
            chki("R2", int_instr, l);
            chki("R2", fp_instr, r);
          end else begin
            chk((rc == 3 && lc != 3) ? "R4" : "R8", lc != 3, lc == 3, 0, 1);
            chki("R8", (lc == 3) ? fp_instr : int_instr, l);
            if (blk) begin
              drive(1, {r, l}, 0);
              chk("R4", 0, 0, 0, 1);
            end
            drive(1, {r, l}, 0);
            chk(blk ? "R11" : "R7", rc != 3, rc == 3, 1, 0);
            chki("R7", (rc == 3) ? fp_instr : int_instr, r);
          end
        end

    // R5: blocked lower slot after a load holds both (R3)
    drive(0, '0, 0);
    l = mk(c_ld, 7, 3, 4, 1);  r = mk(c_fp, 8, 1, 2, 2);
    drive(1, {r, l}, 0);
    chk("R2", 1, 1, 1, 0);
    l2 = mk(c_alu, 12, 7, 2, 3);  r2 = mk(c_fp, 9, 10, 11, 4);
    drive(1, {r2, l2}, 0);
    chk("R3/R5", 0, 0, 0, 1);
    drive(1, {r2, l2}, 0);
    chk("R11", 1, 1, 1, 0);
    chki("R11", int_instr, l2);

    // R5: upper slot of next pair blocked, lower issues
    drive(0, '0, 0);
    drive(1, {r, l}, 0);
    chk("R2", 1, 1, 1, 0);
    l2 = mk(c_alu, 12, 3, 4, 5);  r2 = mk(c_fp, 9, 1, 7, 6);
    drive(1, {r2, l2}, 0);
    chk("R5", 1, 0, 0, 1);
    drive(1, {r2, l2}, 0);
    chk("R11", 0, 1, 1, 0);
    chki("R7", fp_instr, r2);

    // R6: register 0 never blocks
    drive(0, '0, 0);
    l = mk(c_ld, 0, 0, 2, 7);  r = mk(c_fp, 8, 0, 1, 8);
    drive(1, {r, l}, 0);
    chk("R6", 1, 1, 1, 0);
    l2 = mk(c_alu, 3, 0, 0, 9);  r2 = mk(c_fp, 4, 0, 0, 10);
    drive(1, {r2, l2}, 0);
    chk("R6", 1, 1, 1, 0);

    // R11: load from a retried upper slot blocks the next cycle
    drive(0, '0, 0);
    l = mk(c_alu, 3, 1, 2, 11);  r = mk(c_ld, 9, 1, 2, 12);
    drive(1, {r, l}, 0);
    chk("R8", 1, 0, 0, 1);
    drive(1, {r, l}, 0);
    chk("R8", 1, 0, 1, 0);
    chki("R8", int_instr, r);
    l2 = mk(c_alu, 4, 9, 1, 13);  r2 = mk(c_fp, 1, 2, 3, 14);
    drive(1, {r2, l2}, 0);
    chk("R11", 0, 0, 0, 1);
    drive(1, {r2, l2}, 0);
    chk("R11", 1, 1, 1, 0);

    // R9: flush drops a pending retry
    drive(0, '0, 0);
    l = mk(c_ld, 5, 1, 2, 15);  r = mk(c_fp, 6, 5, 4, 16);
    drive(1, {r, l}, 0);
    chk("R4", 1, 0, 0, 1);
    drive(1, {r, l}, 1);
    chk("R9", 0, 0, 1, 0);
    l2 = mk(c_alu, 3, 1, 2, 17);  r2 = mk(c_fp, 4, 1, 2, 18);
    drive(1, {r2, l2}, 0);
    chk("R9", 1, 1, 1, 0);
    chki("R9", int_instr, l2);

    // R1: reset clears a pending retry
    l = mk(c_alu, 3, 1, 2, 19);  r = mk(c_alu, 4, 1, 2, 20);
    drive(1, {r, l}, 0);
    chk("R8", 1, 0, 0, 1);
    @(negedge clk);
    rst = 1'b1;
    #1;
    chk("R1", 0, 0, 0, 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", 1, 0, 0, 1);
    chki("R1", int_instr, l);

    drive(0, '0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule